// File: doc/BRIEF.md
# Trigger Stub Link Formatter

This block sits at the boundary between two trigger processors that trade track-segment stubs over a parallel link. A new frame crosses the link in every 40 MHz cycle. In the transmit direction it packs up to `N_TX` local stubs into one outgoing frame. Each stub carries an azimuth, a region flag and a quality that is squeezed from four bits to three. A frame trailer follows the stubs. It holds the two low bits of a running bunch-crossing counter, an alternating clock bit and a crossing-zero marker.

In the receive direction the block splits an incoming frame of `N_RX` companion stubs into separate fields: azimuth, bend angle, quality and a flag marking a muon from the previous crossing. A stub with quality zero counts as empty, and its fields are forced to zero on both sides.

A small synchronisation state machine owns the local bunch-crossing counter. It starts in `SYNC_HUNT`. It takes the transition *hunt-to-locked* when the first crossing-zero marker arrives in any incoming stub, and then holds in `SYNC_LOCKED` (transition *locked-hold*) until reset. Every marker clears the counter. Once locked, the block forwards its own crossing-zero marker on transmit and flags incoming stubs whose crossing number disagrees with the local count.

Top module: `stub_link_fmt`

## Requirements
- R1: One cycle after the inputs are applied, outgoing stub i sits in `tx_frame` bits [16i+15:16i]. Within the stub, the azimuth is in bits [11:0], the region flag in bit 12 and the 3-bit quality in bits [15:13].
- R2: The 4-bit input quality maps to 3 bits with saturation. Values 1 to 7 pass through unchanged, and 8 to 15 become 7.
- R3: An outgoing stub whose input quality is 0 is sent as sixteen zero bits.
- R4: The frame trailer follows the stubs. Bits [16N+1:16N] hold the counter's two low bits from the cycle the frame was built. Bit 16N+2 is a clock bit that reads 0, 1, 0, 1, ... on successive frames after reset. Bit 16N+3 is the crossing-zero marker, set only when the machine is locked and the counter was 0.
- R5: The local counter becomes 0 in the cycle after an incoming marker. Otherwise it increments every cycle and wraps from `ORBIT_LEN`-1 to 0.
- R6: After reset the machine is in `SYNC_HUNT` and `bx_locked` is 0. The first incoming marker moves it to `SYNC_LOCKED` in the next cycle, and it stays there. The marker of an incoming stub is bit 24.
- R7: Incoming stub i occupies `rx_frame` bits [25i+24:25i]. Its fields sit at these bit positions: azimuth [11:0], bend [16:12], quality [19:17], previous-crossing flag [20], crossing number [22:21], clock [23], marker [24]. One cycle later they appear on `rx_phi`, `rx_bend`, `rx_qual` and `rx_prev_bx`, and `rx_valid` is high.
- R8: An incoming stub with quality 0 gives zero on all its outputs, and its `rx_valid` bit is low.
- R9: `rx_bx_err` rises one cycle after a frame that meets three conditions: the machine is locked, no stub carries a marker, and a non-empty stub's crossing number differs from the counter's two low bits. Empty stubs are never compared.
- R10: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_phi | input | 12*N_TX | Azimuth of each outgoing stub |
| tx_region | input | N_TX | Region flag of each outgoing stub |
| tx_qual | input | 4*N_TX | Full quality of each outgoing stub |
| tx_frame | output | 16*N_TX+4 | Packed outgoing frame |
| rx_frame | input | 25*N_RX | Incoming frame |
| rx_phi | output | 12*N_RX | Unpacked azimuths |
| rx_bend | output | 5*N_RX | Unpacked bend angles |
| rx_qual | output | 3*N_RX | Unpacked qualities |
| rx_prev_bx | output | N_RX | Previous-crossing flags |
| rx_valid | output | N_RX | Non-empty stub indicators |
| rx_bx_err | output | 1 | Crossing-number disagreement |
| bx_locked | output | 1 | Synchronisation machine is locked |

## Verification
A marker and a crossing-number disagreement can arrive in the same frame. The bench provokes this by putting a non-empty stub with a wrong crossing number beside a stub carrying the marker. It then judges that `rx_bx_err` stays low and that the next frame's trailer shows a counter of zero. A marker can also land on a counter that is already at its wrap point. A second coincidence covers the wrap: a full orbit run checks that the transmit marker appears exactly once per wrap. The bench checks every trailer against its own counter model.

// File: rtl/stub_link_pkg.sv
package stub_link_pkg;
    localparam int PHI_W      = 12;
    localparam int BEND_W     = 5;
    localparam int QRAW_W     = 4;
    localparam int QLINK_W    = 3;
    localparam int BXL_W      = 2;
    localparam int TX_STUB_W  = PHI_W + 1 + QLINK_W;
    localparam int RX_STUB_W  = PHI_W + BEND_W + QLINK_W + 1 + BXL_W + 2;

    typedef enum logic {
        SYNC_HUNT   = 1'b0,
        SYNC_LOCKED = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic [QLINK_W-1:0] qual;
        logic               region;
        logic [PHI_W-1:0]   phi;
    } tx_stub_t;

    typedef struct packed {
        logic               bc0;
        logic               lclk;
        logic [BXL_W-1:0]   bxn;
        logic               prev_bx;
        logic [QLINK_W-1:0] qual;
        logic [BEND_W-1:0]  bend;
        logic [PHI_W-1:0]   phi;
    } rx_stub_t;
endpackage

// File: rtl/slf_tx_stub.sv
module slf_tx_stub
    import stub_link_pkg::*;
(
    input  logic [PHI_W-1:0]  phi_i,
    input  logic              region_i,
    input  logic [QRAW_W-1:0] qual_i,
    output tx_stub_t          stub_o
);
    localparam logic [QLINK_W-1:0] QMAX = '1;

    logic [QLINK_W-1:0] q_red;

    always_comb begin
        if (qual_i > QRAW_W'(QMAX)) q_red = QMAX;
        else                        q_red = qual_i[QLINK_W-1:0];
        if (q_red == '0) begin
            stub_o = '0;
        end else begin
            stub_o.qual   = q_red;
            stub_o.region = region_i;
            stub_o.phi    = phi_i;
        end
    end
endmodule

// File: rtl/slf_rx_stub.sv
module slf_rx_stub
    import stub_link_pkg::*;
(
    input  rx_stub_t           stub_i,
    output logic [PHI_W-1:0]   phi_o,
    output logic [BEND_W-1:0]  bend_o,
    output logic [QLINK_W-1:0] qual_o,
    output logic               prev_o,
    output logic               valid_o,
    output logic [BXL_W-1:0]   bxn_o,
    output logic               marker_o
);
    logic lclk_unused;
    assign lclk_unused = stub_i.lclk;

    always_comb begin
        valid_o  = (stub_i.qual != '0);
        phi_o    = valid_o ? stub_i.phi     : '0;
        bend_o   = valid_o ? stub_i.bend    : '0;
        qual_o   = stub_i.qual;
        prev_o   = valid_o ? stub_i.prev_bx : 1'b0;
        bxn_o    = stub_i.bxn;
        marker_o = stub_i.bc0;
    end
endmodule

// File: rtl/slf_bx_sync.sv
module slf_bx_sync
    import stub_link_pkg::*;
#(
    parameter int N_STUB    = 2,
    parameter int ORBIT_LEN = 3564,
    localparam int BX_W     = $clog2(ORBIT_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    marker_i,
    input  logic [N_STUB*BXL_W-1:0] bxn_i,
    input  logic [N_STUB-1:0]       valid_i,
    output logic [BX_W-1:0]         cnt_o,
    output logic                    locked_o,
    output logic                    err_o
);
    localparam logic [BX_W-1:0] CNT_LAST = BX_W'(ORBIT_LEN - 1);

    sync_state_e     state_q, state_d;
    logic [BX_W-1:0] cnt_q, cnt_d;
    logic            err_q, err_d;
    logic            mismatch;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC_HUNT;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d  = state_q;
        mismatch = 1'b0;
        for (int i = 0; i < N_STUB; i++) begin
            if (valid_i[i] && (bxn_i[i*BXL_W +: BXL_W] != cnt_q[BXL_W-1:0]))
                mismatch = 1'b1;
        end
        unique case (state_q)
            SYNC_HUNT:   if (marker_i) state_d = SYNC_LOCKED;
            SYNC_LOCKED: state_d = SYNC_LOCKED;
        endcase
        if (marker_i)               cnt_d = '0;
        else if (cnt_q == CNT_LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
        err_d    = (state_q == SYNC_LOCKED) && !marker_i && mismatch;
        locked_o = (state_q == SYNC_LOCKED);
        cnt_o    = cnt_q;
        err_o    = err_q;
    end

    a_r5_zero_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
        marker_i |=> (cnt_q == '0));
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!marker_i && cnt_q != CNT_LAST) |=> (cnt_q == BX_W'($past(cnt_q) + 1'b1)));
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
    a_r6_lock_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
        marker_i |=> locked_o);
    a_r9_err_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(locked_o) && !$past(marker_i));
endmodule

// File: rtl/stub_link_fmt.sv
module stub_link_fmt
    import stub_link_pkg::*;
#(
    parameter int N_TX      = 3,
    parameter int N_RX      = 2,
    parameter int ORBIT_LEN = 3564,
    localparam int TX_FRAME_W = N_TX*TX_STUB_W + BXL_W + 2,
    localparam int BX_W       = $clog2(ORBIT_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_TX*PHI_W-1:0]   tx_phi,
    input  logic [N_TX-1:0]         tx_region,
    input  logic [N_TX*QRAW_W-1:0]  tx_qual,
    output logic [TX_FRAME_W-1:0]   tx_frame,
    input  logic [N_RX*RX_STUB_W-1:0] rx_frame,
    output logic [N_RX*PHI_W-1:0]   rx_phi,
    output logic [N_RX*BEND_W-1:0]  rx_bend,
    output logic [N_RX*QLINK_W-1:0] rx_qual,
    output logic [N_RX-1:0]         rx_prev_bx,
    output logic [N_RX-1:0]         rx_valid,
    output logic                    rx_bx_err,
    output logic                    bx_locked
);
    localparam int TRL = N_TX*TX_STUB_W;

    tx_stub_t                 tx_st [N_TX];
    logic [TX_FRAME_W-1:0]    tx_frame_d;
    logic                     tx_phase_q;
    logic [N_RX*PHI_W-1:0]    rx_phi_d;
    logic [N_RX*BEND_W-1:0]   rx_bend_d;
    logic [N_RX*QLINK_W-1:0]  rx_qual_d;
    logic [N_RX-1:0]          rx_prev_d, rx_valid_d, rx_mark;
    logic [N_RX*BXL_W-1:0]    rx_bxn;
    logic [BX_W-1:0]          bx_cnt;
    logic                     locked, bx_err;

    for (genvar g = 0; g < N_TX; g++) begin : g_tx
        slf_tx_stub u_tx (
            .phi_i    (tx_phi[g*PHI_W +: PHI_W]),
            .region_i (tx_region[g]),
            .qual_i   (tx_qual[g*QRAW_W +: QRAW_W]),
            .stub_o   (tx_st[g])
        );
    end

    for (genvar g = 0; g < N_RX; g++) begin : g_rx
        slf_rx_stub u_rx (
            .stub_i   (rx_stub_t'(rx_frame[g*RX_STUB_W +: RX_STUB_W])),
            .phi_o    (rx_phi_d[g*PHI_W +: PHI_W]),
            .bend_o   (rx_bend_d[g*BEND_W +: BEND_W]),
            .qual_o   (rx_qual_d[g*QLINK_W +: QLINK_W]),
            .prev_o   (rx_prev_d[g]),
            .valid_o  (rx_valid_d[g]),
            .bxn_o    (rx_bxn[g*BXL_W +: BXL_W]),
            .marker_o (rx_mark[g])
        );
    end

    slf_bx_sync #(.N_STUB(N_RX), .ORBIT_LEN(ORBIT_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .marker_i (|rx_mark),
        .bxn_i    (rx_bxn),
        .valid_i  (rx_valid_d),
        .cnt_o    (bx_cnt),
        .locked_o (locked),
        .err_o    (bx_err)
    );

    always_comb begin
        for (int i = 0; i < N_TX; i++) tx_frame_d[i*TX_STUB_W +: TX_STUB_W] = tx_st[i];
        tx_frame_d[TRL +: BXL_W]   = bx_cnt[BXL_W-1:0];
        tx_frame_d[TRL + BXL_W]    = tx_phase_q;
        tx_frame_d[TRL + BXL_W + 1] = locked && (bx_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_frame   <= '0;
            tx_phase_q <= 1'b0;
            rx_phi     <= '0;
            rx_bend    <= '0;
            rx_qual    <= '0;
            rx_prev_bx <= '0;
            rx_valid   <= '0;
        end else begin
            tx_frame   <= tx_frame_d;
            tx_phase_q <= ~tx_phase_q;
            rx_phi     <= rx_phi_d;
            rx_bend    <= rx_bend_d;
            rx_qual    <= rx_qual_d;
            rx_prev_bx <= rx_prev_d;
            rx_valid   <= rx_valid_d;
        end
    end

    assign rx_bx_err = bx_err;
    assign bx_locked = locked;

    a_r2_quality_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_qual[QRAW_W-1:0] >= 4'd8) |=> (tx_frame[TX_STUB_W-1 -: QLINK_W] == 3'b111));
    a_r3_empty_tx_stub: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_qual[QRAW_W-1:0] == '0) |=> (tx_frame[TX_STUB_W-1:0] == '0));
    a_r8_empty_rx_stub: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame[19:17] == '0) |=> (!rx_valid[0] && rx_phi[PHI_W-1:0] == '0
                                     && rx_bend[BEND_W-1:0] == '0 && !rx_prev_bx[0]));
    a_r4_marker_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame[TX_FRAME_W-1] |-> $past(locked));
endmodule

// File: tb/stub_link_fmt_tb.sv
module stub_link_fmt_tb;
    localparam int N_TX  = 3;
    localparam int N_RX  = 2;
    localparam int ORBIT = 3564;
    localparam int TXW   = N_TX*16 + 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N_TX*12-1:0]  tx_phi = '0;
    logic [N_TX-1:0]     tx_region = '0;
    logic [N_TX*4-1:0]   tx_qual = '0;
    logic [TXW-1:0]      tx_frame;
    logic [N_RX*25-1:0]  rx_frame = '0;
    logic [N_RX*12-1:0]  rx_phi;
    logic [N_RX*5-1:0]   rx_bend;
    logic [N_RX*3-1:0]   rx_qual;
    logic [N_RX-1:0]     rx_prev_bx, rx_valid;
    logic                rx_bx_err, bx_locked;

    stub_link_fmt #(.N_TX(N_TX), .N_RX(N_RX), .ORBIT_LEN(ORBIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_phi(tx_phi), .tx_region(tx_region),
        .tx_qual(tx_qual), .tx_frame(tx_frame), .rx_frame(rx_frame),
        .rx_phi(rx_phi), .rx_bend(rx_bend), .rx_qual(rx_qual),
        .rx_prev_bx(rx_prev_bx), .rx_valid(rx_valid),
        .rx_bx_err(rx_bx_err), .bx_locked(bx_locked)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [11:0] m_cnt = '0;
    logic        m_lock = 0;
    logic        m_clk = 0;

    // {phi, region, qual4, expected stub}
    localparam logic [32:0] TX_VEC [8] = '{
        {12'hABC, 1'b1, 4'd5,  16'hBABC},
        {12'h123, 1'b0, 4'd9,  16'hE123},
        {12'hFFF, 1'b1, 4'd0,  16'h0000},
        {12'h000, 1'b0, 4'd1,  16'h2000},
        {12'h800, 1'b1, 4'd15, 16'hF800},
        {12'h7FF, 1'b0, 4'd7,  16'hE7FF},
        {12'h555, 1'b1, 4'd8,  16'hF555},
        {12'h0F0, 1'b1, 4'd2,  16'h50F0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] mk_rx(input logic [11:0] phi, input logic [4:0] bend,
                                          input logic [2:0] q, input logic prev,
                                          input logic [1:0] bxn, input logic lc, input logic bc0);
        return {bc0, lc, bxn, prev, q, bend, phi};
    endfunction

    // advance one frame; model the trailer, lock and mismatch flag from the requirements
    task automatic step();
        logic mk = 0;
        logic e_err = 0;
        logic [3:0] e_tr;
        for (int i = 0; i < N_RX; i++) begin
            if (rx_frame[i*25+24]) mk = 1;
            if (rx_frame[i*25+17 +: 3] != 3'd0 && rx_frame[i*25+21 +: 2] != m_cnt[1:0]) e_err = 1;
        end
        e_err = e_err && m_lock && !mk;
        e_tr  = {m_lock && (m_cnt == 0), m_clk, m_cnt[1:0]};
        if (mk) m_cnt = '0;
        else if (m_cnt == 12'(ORBIT-1)) m_cnt = '0;
        else m_cnt = m_cnt + 1'b1;
        m_lock = m_lock | mk;
        m_clk  = ~m_clk;
        @(posedge clk);
        @(negedge clk);
        check("R4 trailer", 64'(tx_frame[TXW-1 -: 4]), 64'(e_tr));
        check("R9 mismatch flag", 64'(rx_bx_err), 64'(e_err));
        check("R6 lock state", 64'(bx_locked), 64'(m_lock));
    endtask

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 tx_frame in reset", 64'(tx_frame), 64'd0);
        check("R10 rx outputs in reset", 64'({rx_phi, rx_bend, rx_qual, rx_prev_bx, rx_valid, rx_bx_err}), 64'd0);
        check("R10 lock in reset", 64'(bx_locked), 64'd0);
        rst_n = 1'b1;

        // R6: unlocked frame with counter 0 carries no marker (checked inside step)
        step();

        // R1 R2 R3: vector table
        for (int v = 0; v < 8; v++) begin
            tx_phi    = {N_TX{TX_VEC[v][32:21]}};
            tx_region = {N_TX{TX_VEC[v][20]}};
            tx_qual   = {N_TX{TX_VEC[v][19:16]}};
            step();
            check("R1 R2 R3 stub packing", 64'(tx_frame[N_TX*16-1:0]), 64'({N_TX{TX_VEC[v][15:0]}}));
        end
        tx_qual = '0;

        // R5 R6: marker on stub 1 (empty)
        rx_frame = {mk_rx(12'h0, 5'h0, 3'd0, 1'b0, 2'd3, 1'b0, 1'b1), 25'd0};
        step();
        check("R6 locked after marker", 64'(bx_locked), 64'd1);
        rx_frame = '0;
        for (int k = 0; k < 5; k++) step();   // R5 counter 0,1,2,3,4 seen in trailers

        // R7 R8 R9: unpack with matching crossing number, empty stub with wrong one
        rx_frame = {mk_rx(12'hFFF, 5'h1F, 3'd0, 1'b1, m_cnt[1:0] + 2'd1, 1'b1, 1'b0),
                    mk_rx(12'h9A5, 5'h13, 3'd6, 1'b1, m_cnt[1:0], 1'b1, 1'b0)};
        step();
        check("R7 phi", 64'(rx_phi), 64'({12'h000, 12'h9A5}));
        check("R7 bend", 64'(rx_bend), 64'({5'h00, 5'h13}));
        check("R7 qual", 64'(rx_qual), 64'({3'd0, 3'd6}));
        check("R7 prev flag", 64'(rx_prev_bx), 64'(2'b01));
        check("R8 valid", 64'(rx_valid), 64'(2'b01));

        // R9: non-empty stub with wrong crossing number
        rx_frame = {25'd0, mk_rx(12'h321, 5'h02, 3'd7, 1'b0, m_cnt[1:0] ^ 2'd2, 1'b0, 1'b0)};
        step();
        check("R9 mismatch raised", 64'(rx_bx_err), 64'd1);

        // R9 R5: mismatch in the same frame as a marker is suppressed, counter restarts
        rx_frame = {mk_rx(12'h0, 5'h0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1),
                    mk_rx(12'h321, 5'h02, 3'd7, 1'b0, m_cnt[1:0] ^ 2'd1, 1'b0, 1'b0)};
        step();
        check("R9 suppressed on marker", 64'(rx_bx_err), 64'd0);
        check("R8 R7 stub kept", 64'(rx_valid), 64'(2'b01));
        rx_frame = '0;

        // R5: wrap at orbit length, transmit marker once per orbit
        seen = 0;
        for (int k = 0; k < ORBIT + 1; k++) begin
            step();
            if (tx_frame[TXW-1]) seen++;
        end
        check("R5 wrap marker count", 64'(seen), 64'd2);

        // R3: single empty stub among full ones
        tx_phi = {12'hAAA, 12'hBBB, 12'hCCC};
        tx_region = 3'b111;
        tx_qual = {4'd3, 4'd0, 4'd12};
        step();
        check("R3 middle stub empty", 64'(tx_frame[47:0]), 64'({16'h7AAA, 16'h0000, 16'hFCCC}));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule